// File: doc/BRIEF.md
# Streaming 5x5 Convolution Edge Classifier

This block takes a raster stream of 8-bit pixels and classifies each pixel position as edge or non-edge. A bank of line stores, one image line each, holds the previous rows. Together with the incoming pixel they fill a square neighbourhood, 5x5 by default. Each neighbourhood row goes to its own pipelined multiply-accumulate unit, with one multiplier per tap, and all rows work at once. The row results are added, the absolute value of the total is the filter magnitude, and a strict comparison against a programmable threshold gives a one-bit edge flag for the pixel at the centre of the window.

The kernel is not fixed in logic. Software writes 25 signed coefficients into a staging bank through a simple write port. The kernel actually in use is copied from that staging bank only when the first pixel of a frame is accepted, so the filter can be retuned for noise level between frames and a frame is never processed with two kernels. One result leaves the block for every accepted pixel, at a fixed distance behind it, and the stream may pause (valid low) at any time without disturbing alignment.

Top module: `edge_filter_top`

## Requirements
- R1: For an accepted pixel at line r, column c (both counted from 0, r,c >= 4), out_mag equals |sum over i,j in 0..4 of P(r-4+i, c-4+j) * K[5*i+j]|, where K[a] is the coefficient written at address a, i counts window rows from the top and j window columns from the left; the window centre is P(r-2, c-2).
- R2: out_valid is high exactly in the cycle registered four clock edges after the edge that accepted a pixel (pix_valid high), one result per accepted pixel, at up to one pixel per clock.
- R3: When the accepted pixel has r < 4 or c < 4, the result is still delivered but out_mag is 0 and out_edge is 0.
- R4: out_edge is 1 only when out_mag is strictly greater than thresh; a magnitude equal to thresh gives 0.
- R5: Coefficients are 8-bit two's complement; the sum never overflows, so 25 pixels of 255 with all coefficients -128 give out_mag 816000.
- R6: A coefficient write changes only the staging bank; the kernel in use is replaced by the staging bank when a pixel with pix_sof high is accepted, so results of a frame in progress keep the old kernel.
- R7: After reset out_valid, out_mag and out_edge are 0 and the kernel in use and the staging bank are all zero, so a frame started without writes yields magnitude 0.
- R8: pix_sol (or pix_sof) on an accepted pixel sets its column to 0, pix_sof sets its line to 0, pix_sol alone advances the line; cycles with pix_valid low change no state.
- R9: While out_valid is low, out_mag and out_edge are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel present on pix_data this cycle |
| pix_sol | input | 1 | Accepted pixel is the first of a line |
| pix_sof | input | 1 | Accepted pixel is the first of a frame (also line start) |
| pix_data | input | 8 | Unsigned pixel value |
| coef_we | input | 1 | Write one staging coefficient |
| coef_addr | input | 5 | Coefficient address 5*row+column; 25..31 ignored |
| coef_data | input | 8 | Signed coefficient value |
| thresh | input | 22 | Edge threshold, compared against the magnitude |
| out_valid | output | 1 | Result present |
| out_mag | output | 22 | Absolute filter response |
| out_edge | output | 1 | Centre pixel classified as edge |

## Verification
A pixel accepted at a clock edge produces its magnitude, flag and valid in the registers updated four edges later, so the bench reads them at the falling edge that follows that fifth edge. The reference model stamps each expected result with its due cycle (the cycle count when the pixel was driven plus five) and, on every falling edge, compares outputs either with the result due then or with the idle state of all zeros. Threshold changes and kernel swaps are made only once the pipeline has drained, so every queued expectation was computed with the settings the hardware used.

// File: rtl/edge_filt_pkg.sv
package edge_filt_pkg;

   // Signed accumulator width: unsigned pixel times signed coefficient,
   // one guard bit for the sign, plus growth for the number of taps.
   function automatic int acc_width(input int pix_w, input int coef_w, input int taps);
      return pix_w + coef_w + 1 + $clog2(taps);
   endfunction

   // Largest magnitude the filter can reach (all pixels full scale,
   // all coefficients at the most negative value).
   function automatic longint peak_mag(input int pix_w, input int coef_w, input int taps);
      return longint'(taps) * ((longint'(1) << pix_w) - 1) * (longint'(1) << (coef_w - 1));
   endfunction

endpackage

// File: rtl/edge_line_window.sv
module edge_line_window #(
   parameter int PIX_W = 8,
   parameter int KS    = 5,
   parameter int IMG_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_sol,
   input  logic                    in_sof,
   input  logic [PIX_W-1:0]        in_pix,
   output logic [KS*KS*PIX_W-1:0]  win_flat,
   output logic                    win_valid,
   output logic                    win_full
);
   localparam int NLB = KS - 1;
   localparam int CW  = $clog2(KS);
   localparam logic [CW-1:0] LAST = CW'(KS - 1);

   logic [PIX_W-1:0] lb     [NLB][IMG_W];
   logic [PIX_W-1:0] col_in [KS];
   logic [PIX_W-1:0] win    [KS][KS];
   logic [CW-1:0]    col_q, row_q, col_d, row_d;

   // Column entering the window: oldest line at row 0, live pixel at the bottom.
   always_comb begin
      col_in[KS-1] = in_pix;
      for (int r = 0; r < KS - 1; r++) col_in[r] = lb[KS-2-r][IMG_W-1];
   end

   // Position counters saturate once the window is fully inside the image.
   always_comb begin
      if (in_sof || in_sol)   col_d = '0;
      else if (col_q == LAST) col_d = col_q;
      else                    col_d = col_q + 1'b1;
      if (in_sof)                     row_d = '0;
      else if (in_sol && row_q != LAST) row_d = row_q + 1'b1;
      else                            row_d = row_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q     <= '0;
         row_q     <= '0;
         win_valid <= 1'b0;
         win_full  <= 1'b0;
         for (int l = 0; l < NLB; l++)
            for (int x = 0; x < IMG_W; x++) lb[l][x] <= '0;
         for (int r = 0; r < KS; r++)
            for (int c = 0; c < KS; c++) win[r][c] <= '0;
      end else begin
         win_valid <= in_valid;
         win_full  <= in_valid && (col_d == LAST) && (row_d == LAST);
         if (in_valid) begin
            col_q    <= col_d;
            row_q    <= row_d;
            lb[0][0] <= in_pix;
            for (int l = 1; l < NLB; l++) lb[l][0] <= lb[l-1][IMG_W-1];
            for (int l = 0; l < NLB; l++)
               for (int x = 1; x < IMG_W; x++) lb[l][x] <= lb[l][x-1];
            for (int r = 0; r < KS; r++) begin
               for (int c = 0; c < KS - 1; c++) win[r][c] <= win[r][c+1];
               win[r][KS-1] <= col_in[r];
            end
         end
      end
   end

   always_comb begin
      for (int r = 0; r < KS; r++)
         for (int c = 0; c < KS; c++)
            win_flat[(r*KS+c)*PIX_W +: PIX_W] = win[r][c];
   end

endmodule

// File: rtl/edge_coef_bank.sv
module edge_coef_bank #(
   parameter int COEF_W = 8,
   parameter int NCOEF  = 25,
   parameter int AW     = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [COEF_W-1:0]         wr_data,
   input  logic                      load,
   output logic [NCOEF*COEF_W-1:0]   act_flat
);
   logic [COEF_W-1:0] stage [NCOEF];
   logic [COEF_W-1:0] live  [NCOEF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < NCOEF; a++) begin
            stage[a] <= '0;
            live[a]  <= '0;
         end
      end else begin
         for (int a = 0; a < NCOEF; a++) begin
            if (wr_en && wr_addr == AW'(a)) stage[a] <= wr_data;
            if (load) live[a] <= stage[a];
         end
      end
   end

   always_comb begin
      for (int a = 0; a < NCOEF; a++) act_flat[a*COEF_W +: COEF_W] = live[a];
   end

endmodule

// File: rtl/edge_row_mac.sv
module edge_row_mac #(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter int KS     = 5,
   parameter int SUM_W  = 20
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [KS*PIX_W-1:0]        pix_row,
   input  logic [KS*COEF_W-1:0]       coef_row,
   output logic signed [SUM_W-1:0]    row_sum
);
   localparam int PW = PIX_W + COEF_W + 1;

   logic signed [PW-1:0]    prod_q [KS];
   logic signed [SUM_W-1:0] acc;

   always_comb begin
      acc = '0;
      for (int t = 0; t < KS; t++) acc = acc + SUM_W'(prod_q[t]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < KS; t++) prod_q[t] <= '0;
         row_sum <= '0;
      end else begin
         for (int t = 0; t < KS; t++)
            prod_q[t] <= PW'($signed({1'b0, pix_row[t*PIX_W +: PIX_W]}))
                       * PW'($signed(coef_row[t*COEF_W +: COEF_W]));
         row_sum <= acc;
      end
   end

endmodule

// File: rtl/edge_filter_top.sv
module edge_filter_top #(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter int KS     = 5,
   parameter int IMG_W  = 16,
   parameter int ACC_W  = edge_filt_pkg::acc_width(PIX_W, COEF_W, KS*KS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           pix_valid,
   input  logic                           pix_sol,
   input  logic                           pix_sof,
   input  logic [PIX_W-1:0]               pix_data,
   input  logic                           coef_we,
   input  logic [$clog2(KS*KS)-1:0]       coef_addr,
   input  logic [COEF_W-1:0]              coef_data,
   input  logic [ACC_W-1:0]               thresh,
   output logic                           out_valid,
   output logic [ACC_W-1:0]               out_mag,
   output logic                           out_edge
);
   localparam int NCOEF = KS * KS;
   localparam int AW    = $clog2(NCOEF);
   localparam int PW    = PIX_W + COEF_W + 1;
   localparam int SUM_W = PW + $clog2(KS);

   if (KS < 3 || (KS % 2) == 0) begin : g_bad_ks
      $error("edge_filter_top: KS must be odd and at least 3");
   end
   if (IMG_W < KS) begin : g_bad_w
      $error("edge_filter_top: IMG_W must be at least KS");
   end
   if (ACC_W < edge_filt_pkg::acc_width(PIX_W, COEF_W, NCOEF)) begin : g_bad_acc
      $error("edge_filter_top: ACC_W too narrow for the kernel");
   end

   logic [NCOEF*PIX_W-1:0]  win_flat;
   logic                    win_valid, win_full;
   logic [NCOEF*COEF_W-1:0] coef_act;
   logic signed [SUM_W-1:0] row_sum [KS];
   logic signed [ACC_W-1:0] total;
   logic [ACC_W-1:0]        mag_q;
   logic [2:0]              vld_q, full_q;

   edge_line_window #(.PIX_W(PIX_W), .KS(KS), .IMG_W(IMG_W)) u_win (
      .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_sol(pix_sol),
      .in_sof(pix_sof), .in_pix(pix_data), .win_flat(win_flat),
      .win_valid(win_valid), .win_full(win_full)
   );

   edge_coef_bank #(.COEF_W(COEF_W), .NCOEF(NCOEF), .AW(AW)) u_coef (
      .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_addr(coef_addr),
      .wr_data(coef_data), .load(pix_valid && pix_sof), .act_flat(coef_act)
   );

   for (genvar r = 0; r < KS; r++) begin : g_row
      edge_row_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .KS(KS), .SUM_W(SUM_W)) u_mac (
         .clk(clk), .rst_n(rst_n),
         .pix_row(win_flat[r*KS*PIX_W +: KS*PIX_W]),
         .coef_row(coef_act[r*KS*COEF_W +: KS*COEF_W]),
         .row_sum(row_sum[r])
      );
   end

   always_comb begin
      total = '0;
      for (int r = 0; r < KS; r++) total = total + ACC_W'(row_sum[r]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q     <= '0;
         full_q    <= '0;
         mag_q     <= '0;
         out_valid <= 1'b0;
         out_mag   <= '0;
         out_edge  <= 1'b0;
      end else begin
         vld_q     <= {vld_q[1:0], win_valid};
         full_q    <= {full_q[1:0], win_full};
         mag_q     <= (total < 0) ? -total : total;
         out_valid <= vld_q[2];
         if (vld_q[2] && full_q[2]) begin
            out_mag  <= mag_q;
            out_edge <= mag_q > thresh;
         end else begin
            out_mag  <= '0;
            out_edge <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/edge_filter_chk.sv
module edge_filter_chk #(
   parameter int          ACC_W = 22,
   parameter int          KBITS = 200,
   parameter longint      PEAK  = 816000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_valid,
   input logic             pix_sof,
   input logic [ACC_W-1:0] thresh,
   input logic             out_valid,
   input logic [ACC_W-1:0] out_mag,
   input logic             out_edge,
   input logic [KBITS-1:0] coef_act
);
   logic [2:0] since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            since <= '0;
      else if (since != 3'd7) since <= since + 3'd1;
   end

   // R2: valid leaves exactly four register stages after acceptance
   a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since >= 3'd5) |-> (out_valid == $past(pix_valid, 5)));

   // R9: quiet outputs between results
   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_mag == '0 && !out_edge));

   // R4: a flagged edge always lies strictly above the threshold it was compared with
   a_r4_edge_above: assert property (@(posedge clk) disable iff (!rst_n)
      out_edge |-> (out_mag > $past(thresh)));

   // R6: the kernel in use changes only after a frame-start pixel was accepted
   a_r6_kernel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (since >= 3'd1 && !$past(pix_valid && pix_sof)) |-> $stable(coef_act));

   // R5: magnitude never exceeds the arithmetic peak
   a_r5_peak_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_mag <= ACC_W'(PEAK));

endmodule

bind edge_filter_top edge_filter_chk #(
   .ACC_W(ACC_W),
   .KBITS(KS*KS*COEF_W),
   .PEAK(edge_filt_pkg::peak_mag(PIX_W, COEF_W, KS*KS))
) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
   .thresh(thresh), .out_valid(out_valid), .out_mag(out_mag),
   .out_edge(out_edge), .coef_act(coef_act)
);

// File: tb/tb_edge_filter_top.sv
module tb_edge_filter_top;
   localparam int PIX_W = 8, COEF_W = 8, KS = 5, IMG_W = 16, NC = 25, AW = 5;
   localparam int ACC_W = edge_filt_pkg::acc_width(PIX_W, COEF_W, NC);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, pix_valid, pix_sol, pix_sof, coef_we;
   logic [PIX_W-1:0]  pix_data;
   logic [AW-1:0]     coef_addr;
   logic [COEF_W-1:0] coef_data;
   logic [ACC_W-1:0]  thresh;
   logic              out_valid, out_edge;
   logic [ACC_W-1:0]  out_mag;

   edge_filter_top #(.PIX_W(PIX_W), .COEF_W(COEF_W), .KS(KS), .IMG_W(IMG_W)) dut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sol(pix_sol),
      .pix_sof(pix_sof), .pix_data(pix_data), .coef_we(coef_we),
      .coef_addr(coef_addr), .coef_data(coef_data), .thresh(thresh),
      .out_valid(out_valid), .out_mag(out_mag), .out_edge(out_edge)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, fails = 0;
   int img [0:15][0:IMG_W-1];
   int kact [NC];
   int kshd [NC];
   longint thr = 0;
   string mag_tag = "R1";

   int     q_due [$];
   longint q_mag [$];
   bit     q_edge [$];
   bit     q_full [$];
   string  q_tag [$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   function automatic int kval(input int kind, input int a);
      int i = a / KS, j = a % KS;
      case (kind)
         0: return j - 2;                        // horizontal gradient
         1: return ((a * 37 + 11) % 256) - 128;  // scattered signed values
         2: return (a == 12) ? 1 : 0;            // centre tap only
         3: return -128;                         // extreme negative
         default: return (i - 2) * ((j == 2) ? 2 : 1);  // vertical gradient
      endcase
   endfunction

   function automatic int pval(input int pat, input int r, input int c);
      case (pat)
         0: return (r * 17 + c * 9) % 256;
         1: return (c < 8) ? 10 : 200;
         2: return (r * 31 + c * 57 + r * c * 13) % 256;
         3: return 255;
         default: return 95 + c;
      endcase
   endfunction

   // Outputs compared on every falling edge against the queued expectations
   always @(negedge clk) begin
      if (rst_n) begin
         while (q_due.size() > 0 && q_due[0] < cyc) begin
            chk(1'b0, "R2", "result missing", 0, 1);
            void'(q_due.pop_front()); void'(q_mag.pop_front());
            void'(q_edge.pop_front()); void'(q_full.pop_front()); void'(q_tag.pop_front());
         end
         if (q_due.size() > 0 && q_due[0] == cyc) begin
            chk(out_valid === 1'b1, "R2", "out_valid", longint'(out_valid), 1);
            chk(out_mag == q_mag[0], q_full[0] ? q_tag[0] : "R3", "out_mag",
                longint'(out_mag), q_mag[0]);
            chk(out_edge == q_edge[0], q_full[0] ? "R4" : "R3", "out_edge",
                longint'(out_edge), longint'(q_edge[0]));
            void'(q_due.pop_front()); void'(q_mag.pop_front());
            void'(q_edge.pop_front()); void'(q_full.pop_front()); void'(q_tag.pop_front());
         end else begin
            chk(out_valid === 1'b0, "R2", "out_valid idle", longint'(out_valid), 0);
            chk(out_mag == '0 && out_edge == 1'b0, "R9", "idle outputs",
                longint'(out_mag) + longint'(out_edge), 0);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         pix_valid = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0; coef_we = 1'b0;
      end
   endtask

   task automatic set_thr(input longint v);
      @(negedge clk);
      pix_valid = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0; coef_we = 1'b0;
      thresh = ACC_W'(v);
      thr = v;
   endtask

   task automatic write_coef(input int a, input int v);
      @(negedge clk);
      pix_valid = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0;
      coef_we = 1'b1; coef_addr = AW'(a); coef_data = COEF_W'(v);
      if (a < NC) kshd[a] = v;
   endtask

   task automatic load_kernel(input int kind);
      for (int a = 0; a < NC; a++) write_coef(a, kval(kind, a));
      idle(1);
   endtask

   task automatic drive_pix(input int r, input int c, input bit sof, input int v);
      longint s = 0;
      bit full;
      @(negedge clk);
      pix_valid = 1'b1; pix_sol = (c == 0); pix_sof = sof; coef_we = 1'b0;
      pix_data = PIX_W'(v);
      img[r][c] = v;
      if (sof) for (int a = 0; a < NC; a++) kact[a] = kshd[a];
      full = (r >= 4) && (c >= 4);
      if (full)
         for (int i = 0; i < KS; i++)
            for (int j = 0; j < KS; j++)
               s += longint'(img[r-4+i][c-4+j]) * kact[i*KS+j];
      if (s < 0) s = -s;
      if (!full) s = 0;
      q_due.push_back(cyc + 5);
      q_mag.push_back(s);
      q_edge.push_back(full && (s > thr));
      q_full.push_back(full);
      q_tag.push_back(mag_tag);
   endtask

   task automatic send_rows(input int r0, input int nr, input int pat, input int gap_every);
      for (int r = r0; r < r0 + nr; r++)
         for (int c = 0; c < IMG_W; c++) begin
            if (gap_every > 0 && ((r * IMG_W + c) % gap_every) == 0) idle(1);
            drive_pix(r, c, (r == 0 && c == 0), pval(pat, r, c));
         end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finish_run();
   end

   initial begin
      for (int a = 0; a < NC; a++) begin kact[a] = 0; kshd[a] = 0; end
      rst_n = 1'b0; pix_valid = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0;
      pix_data = '0; coef_we = 1'b0; coef_addr = '0; coef_data = '0; thresh = '0;
      repeat (3) @(negedge clk);
      // R7: reset state at the ports
      chk(out_valid === 1'b0, "R7", "reset out_valid", longint'(out_valid), 0);
      chk(out_mag == '0, "R7", "reset out_mag", longint'(out_mag), 0);
      chk(out_edge === 1'b0, "R7", "reset out_edge", longint'(out_edge), 0);
      rst_n = 1'b1;

      // R7: no coefficients written yet, kernel in use is all zero
      mag_tag = "R7";
      set_thr(0);
      send_rows(0, 6, 0, 0);
      idle(8);

      // R1: horizontal gradient on a vertical step edge
      load_kernel(0);
      set_thr(300);
      mag_tag = "R1";
      send_rows(0, 8, 1, 0);
      idle(8);

      // R8: valid gaps inside lines; R6: kernel rewritten mid-frame
      load_kernel(1);
      set_thr(5000);
      mag_tag = "R8";
      send_rows(0, 5, 2, 3);
      load_kernel(4);
      mag_tag = "R6";
      send_rows(5, 3, 2, 0);
      idle(8);

      // R1: the mid-frame kernel now takes effect at the next frame start
      mag_tag = "R1";
      send_rows(0, 6, 0, 2);
      idle(8);

      // R4: centre tap only, ramp through the threshold value (equal gives 0)
      load_kernel(2);
      set_thr(100);
      mag_tag = "R4";
      send_rows(0, 6, 4, 0);
      idle(8);

      // R5: extreme values, flag set just below the peak, cleared at equality
      load_kernel(3);
      set_thr(815999);
      mag_tag = "R5";
      send_rows(0, 6, 3, 0);
      idle(8);
      set_thr(816000);
      send_rows(0, 5, 3, 0);
      idle(10);

      chk(q_due.size() == 0, "R2", "results outstanding", q_due.size(), 0);
      finish_run();
   end

endmodule